// File: doc/BRIEF.md
# Capture Buffer Write and Readback Controller

This block sits between the sampling front end of a 16-channel logic capture engine and an on-chip word memory. Each packed 32-bit sample word offered by the front end is stored at the next free memory address. Storing stops on its own once a programmed word count has been stored. Capture data always starts at word address 2, so the valid region runs from address 2 up to address 2 plus the stored count minus 1.

A small register bus controls the block and reads back its state. Through it the host arms the buffer and sets the count limit. It can also read the fill level while a capture runs, and it can read words one at a time through a data port whose read address steps forward after each read. For bulk transfer, a readback sequencer takes a start address and a length. It streams the words one per clock and marks chunk boundaries, either every CHUNK_LONG words or every CHUNK_SHORT words in the reduced-transfer mode.

Writing is armed in a fixed order. The host first sets the clear bit, then removes it, then sets the write-enable bit. Setting the write-enable bit without an earlier clear does nothing.

Top module: `capbuf_ctrl`

## Requirements
- R1: After reset, every register reads as follows: CTRL (select 0) reads 0, FILL (select 1) reads 0, LIMIT (select 2) reads 2^ADDR_W - 5, RPTR (select 3) reads 0. rb_busy, rb_valid and reg_rvalid are 0.
- R2: A CTRL write with bit 0 (clear) set does three things. On the clock after it, FILL becomes 0 and the limit-reached status bit 3 clears. It also arms the buffer, which CTRL shows as bit 4.
- R3: While the buffer is armed, with bit 1 (write enable) set and bit 0 clear, each smp_valid word is stored at address 2 + FILL and FILL increases by one. CTRL bit 2 (live) reads 1 in this state.
- R4: When FILL reaches min(LIMIT, 2^ADDR_W - 2), further sample words are dropped. At that point CTRL bit 2 reads 0, bit 3 reads 1 and bit 4 reads 0, and writing bit 1 again without a new clear stores nothing.
- R5: Setting the write-enable bit when no clear has armed the buffer since reset stores no samples, so FILL stays 0.
- R6: A register read issued with reg_rd is answered on the following clock with reg_rvalid high and reg_rdata holding the selected register. Unmapped selects read as 0.
- R7: Writing RPTR sets the read address. Each read of DATA (select 4) returns the word at that address and then advances RPTR by one. RPTR stops at 2^ADDR_W - 1 and does not wrap.
- R8: Any read, from the DATA register or from a burst, of an address below 2 or at or above 2 + FILL returns 0.
- R9: An rb_req with a nonzero rb_len streams rb_len words, one per clock, starting with address rb_addr on the second clock after the request edge. The address saturates at 2^ADDR_W - 1.
- R10: rb_chunk_end marks every CHUNK_LONG-th word of a burst, or every CHUNK_SHORT-th word when rb_short was set, and also the last word. rb_done marks only the last word.
- R11: While rb_busy is high, a new rb_req is ignored. A DATA read during that time returns 0 and leaves RPTR unchanged.
- R12: An rb_req with rb_len of 0 starts no burst and leaves rb_busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample word offered this cycle |
| smp_data | input | DATA_W | Packed sample word |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select (0 CTRL, 1 FILL, 2 LIMIT, 3 RPTR, 4 DATA) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read answer valid |
| rb_req | input | 1 | Start a readback burst |
| rb_addr | input | ADDR_W | Burst start address |
| rb_len | input | LEN_W | Burst length in words |
| rb_short | input | 1 | Use the short chunk size |
| rb_busy | output | 1 | Burst in progress |
| rb_valid | output | 1 | Burst word valid |
| rb_data | output | DATA_W | Burst word |
| rb_chunk_end | output | 1 | Last word of a chunk |
| rb_done | output | 1 | Last word of the burst |

## Verification
The assertions assume that the host never writes CTRL or LIMIT in the same cycle as a sample word that would fill the buffer. They also assume that samples and burst reads never touch the same address in one clock. The stimulus keeps to this by holding smp_valid low around every register write, and by starting readback only after the capture has stopped. Every register write is followed by an idle clock, so the clear takes effect before the next sample or read.

// File: rtl/capbuf_pkg.sv
// Shared register selects and control/status bit positions for the capture buffer.
package capbuf_pkg;
    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_FILL  = 3'd1,
        SEL_LIMIT = 3'd2,
        SEL_RPTR  = 3'd3,
        SEL_DATA  = 3'd4
    } reg_sel_e;

    localparam int CB_CLR_BIT  = 0;
    localparam int CB_WEN_BIT  = 1;
    localparam int CB_LIVE_BIT = 2;
    localparam int CB_HIT_BIT  = 3;
    localparam int CB_ARM_BIT  = 4;

    // First word address that holds capture data.
    localparam int CB_FIRST_WORD = 2;
endpackage

// File: rtl/capbuf_mem.sv
// Single write port, single synchronous read port word memory.
// Assumes the caller never reads and writes one address in the same cycle.
module capbuf_mem #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] wa,
    input  logic [DATA_W-1:0] wd,
    input  logic              re,
    input  logic [ADDR_W-1:0] ra,
    output logic [DATA_W-1:0] q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] ram [DEPTH];

    // Store one word per write strobe.
    always_ff @(posedge clk) begin
        if (we) ram[wa] <= wd;
    end

    // Registered read port; output holds between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (re) q <= ram[ra];
    end
endmodule

// File: rtl/capbuf_wr.sv
// Write side: control flags, arming, fill counter and count limit.
// Assumes ctl_we/lim_we are single-cycle strobes from the register decoder.
module capbuf_wr
    import capbuf_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              ctl_clr_d,
    input  logic              ctl_wen_d,
    input  logic              lim_we,
    input  logic [CNT_W-1:0]  lim_d,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_wa,
    output logic [DATA_W-1:0] mem_wd,
    output logic [CNT_W-1:0]  fill,
    output logic [CNT_W-1:0]  limit,
    output logic              clr,
    output logic              wen,
    output logic              live,
    output logic              hit,
    output logic              armed
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [CNT_W-1:0] ROOM    = CNT_W'(DEPTH - CB_FIRST_WORD);
    localparam logic [CNT_W-1:0] LIM_RST = CNT_W'(DEPTH - 5);

    logic [CNT_W-1:0] lim_eff;
    logic             accept;

    // Effective limit never lets a write run past the last address.
    always_comb lim_eff = (limit > ROOM) ? ROOM : limit;

    // Capture is live only when armed, enabled, not cleared and below the limit.
    always_comb begin
        live   = armed && wen && !clr && !hit && (fill < lim_eff);
        accept = live && smp_valid;
    end

    // Memory write port driven straight from the accepted sample.
    always_comb begin
        mem_we = accept;
        mem_wa = ADDR_W'(CB_FIRST_WORD) + fill[ADDR_W-1:0];
        mem_wd = smp_data;
    end

    // Control flags, arming, fill counter and limit register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr   <= 1'b0;
            wen   <= 1'b0;
            armed <= 1'b0;
            hit   <= 1'b0;
            fill  <= '0;
            limit <= LIM_RST;
        end else begin
            if (lim_we) limit <= lim_d;
            if (clr) begin
                fill <= '0;
                hit  <= 1'b0;
            end else if (accept) begin
                fill <= fill + 1'b1;
                if (fill + 1'b1 == lim_eff) begin
                    hit   <= 1'b1;
                    armed <= 1'b0;
                end
            end
            if (ctl_we) begin
                clr <= ctl_clr_d;
                wen <= ctl_wen_d;
                if (ctl_clr_d) armed <= 1'b1;
            end
        end
    end

    // R2: a held clear empties the fill count on the next clock.
    a_r2_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fill == '0));
    // R3: each stored word advances the fill count by exactly one.
    a_r3_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (fill == $past(fill) + 1'b1));
    // R4: nothing is stored once the limit has been reached.
    a_r4_no_write_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !mem_we);
    // R4: the fill count never passes the usable memory room.
    a_r4_fill_in_room: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= ROOM);
endmodule

// File: rtl/capbuf_rb.sv
// Readback sequencer: issues one memory read per clock for a burst and
// pipelines valid, chunk-end and done markers alongside the read data.
// Assumes the memory read has one cycle of latency.
module capbuf_rb #(
    parameter int ADDR_W      = 10,
    parameter int LEN_W       = 16,
    parameter int CHUNK_LONG  = 250,
    parameter int CHUNK_SHORT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rb_req,
    input  logic [ADDR_W-1:0] rb_addr,
    input  logic [LEN_W-1:0]  rb_len,
    input  logic              rb_short,
    output logic              busy,
    output logic [ADDR_W-1:0] iss_addr,
    output logic              rb_valid,
    output logic              rb_chunk_end,
    output logic              rb_done
);
    localparam int CHK_W = $clog2(CHUNK_LONG) + 1;
    localparam logic [ADDR_W-1:0] ADDR_MAX = '1;
    localparam logic [CHK_W-1:0]  CLONG    = CHK_W'(CHUNK_LONG);
    localparam logic [CHK_W-1:0]  CSHORT   = CHK_W'(CHUNK_SHORT);

    logic [ADDR_W-1:0] cur;
    logic [LEN_W-1:0]  remain;
    logic [CHK_W-1:0]  chunk;
    logic [CHK_W-1:0]  csize;
    logic              short_q;
    logic              last;
    logic              cend;

    // Chunk size and boundary markers for the word issued this cycle.
    always_comb begin
        csize    = short_q ? CSHORT : CLONG;
        last     = (remain == LEN_W'(1));
        cend     = (chunk == csize - 1'b1) || last;
        iss_addr = cur;
    end

    // Burst state: load on an accepted request, step once per issued word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cur     <= '0;
            remain  <= '0;
            chunk   <= '0;
            short_q <= 1'b0;
        end else if (!busy) begin
            if (rb_req && rb_len != '0) begin
                busy    <= 1'b1;
                cur     <= rb_addr;
                remain  <= rb_len;
                chunk   <= '0;
                short_q <= rb_short;
            end
        end else begin
            remain <= remain - 1'b1;
            if (last) busy <= 1'b0;
            if (cur != ADDR_MAX) cur <= cur + 1'b1;
            chunk <= (chunk == csize - 1'b1) ? '0 : chunk + 1'b1;
        end
    end

    // Markers travel one stage to line up with the memory output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_valid     <= 1'b0;
            rb_chunk_end <= 1'b0;
            rb_done      <= 1'b0;
        end else begin
            rb_valid     <= busy;
            rb_chunk_end <= busy && cend;
            rb_done      <= busy && last;
        end
    end

    // R12: a zero-length request leaves the sequencer idle.
    a_r12_zero_len_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rb_req && rb_len == '0) |=> !busy);
    // R10: the final word always closes a chunk.
    a_r10_done_closes_chunk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_done |-> (rb_chunk_end && rb_valid));
    // R11: a request during a burst does not restart it.
    a_r11_req_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && remain != LEN_W'(1)) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/capbuf_ctrl.sv
// Capture buffer controller top: register decode, read pointer, shared
// memory read port and range masking of every read.
// Assumes at most one of reg_wr/reg_rd per cycle.
module capbuf_ctrl
    import capbuf_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 32,
    parameter int LEN_W       = 16,
    parameter int CHUNK_LONG  = 250,
    parameter int CHUNK_SHORT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    input  logic              rb_req,
    input  logic [ADDR_W-1:0] rb_addr,
    input  logic [LEN_W-1:0]  rb_len,
    input  logic              rb_short,
    output logic              rb_busy,
    output logic              rb_valid,
    output logic [DATA_W-1:0] rb_data,
    output logic              rb_chunk_end,
    output logic              rb_done
);
    localparam int CNT_W = ADDR_W + 1;
    localparam logic [ADDR_W-1:0] RPTR_MAX = '1;
    localparam logic [CNT_W-1:0]  START    = CNT_W'(CB_FIRST_WORD);

    logic              mem_we;
    logic [ADDR_W-1:0] mem_wa;
    logic [DATA_W-1:0] mem_wd;
    logic [DATA_W-1:0] mem_q;
    logic [CNT_W-1:0]  fill;
    logic [CNT_W-1:0]  limit;
    logic              st_clr, st_wen, st_live, st_hit, st_arm;
    logic [ADDR_W-1:0] iss_addr;
    logic [ADDR_W-1:0] rptr;
    logic              ctl_we, lim_we, rptr_we, data_rd_ok;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [CNT_W-1:0]  rd_ext;
    logic              in_rng, range_q, sel_mem_q;
    logic [DATA_W-1:0] rval_q, masked;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata;

    // Register write strobes and the data-port read qualifier.
    always_comb begin
        ctl_we     = reg_wr && (reg_addr == SEL_CTRL);
        lim_we     = reg_wr && (reg_addr == SEL_LIMIT);
        rptr_we    = reg_wr && (reg_addr == SEL_RPTR);
        data_rd_ok = reg_rd && (reg_addr == SEL_DATA) && !rb_busy;
    end

    capbuf_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) wr_i (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_clr_d(reg_wdata[CB_CLR_BIT]), .ctl_wen_d(reg_wdata[CB_WEN_BIT]),
        .lim_we(lim_we), .lim_d(reg_wdata[CNT_W-1:0]),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .mem_we(mem_we), .mem_wa(mem_wa), .mem_wd(mem_wd),
        .fill(fill), .limit(limit),
        .clr(st_clr), .wen(st_wen), .live(st_live), .hit(st_hit), .armed(st_arm)
    );

    capbuf_rb #(.ADDR_W(ADDR_W), .LEN_W(LEN_W),
                .CHUNK_LONG(CHUNK_LONG), .CHUNK_SHORT(CHUNK_SHORT)) rb_i (
        .clk(clk), .rst_n(rst_n),
        .rb_req(rb_req), .rb_addr(rb_addr), .rb_len(rb_len), .rb_short(rb_short),
        .busy(rb_busy), .iss_addr(iss_addr),
        .rb_valid(rb_valid), .rb_chunk_end(rb_chunk_end), .rb_done(rb_done)
    );

    // Read port arbitration: a running burst owns the port.
    always_comb begin
        rd_en   = rb_busy || data_rd_ok;
        rd_addr = rb_busy ? iss_addr : rptr;
        rd_ext  = CNT_W'(rd_addr);
        in_rng  = (rd_ext >= START) && ((rd_ext - START) < fill);
    end

    capbuf_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
        .clk(clk), .rst_n(rst_n),
        .we(mem_we), .wa(mem_wa), .wd(mem_wd),
        .re(rd_en), .ra(rd_addr), .q(mem_q)
    );

    // Read pointer: host load wins, otherwise post-increment with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)                               rptr <= '0;
        else if (rptr_we)                         rptr <= reg_wdata[ADDR_W-1:0];
        else if (data_rd_ok && rptr != RPTR_MAX)  rptr <= rptr + 1'b1;
    end

    // Range flag travels with the memory read it belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n)     range_q <= 1'b0;
        else if (rd_en) range_q <= in_rng;
    end

    // Register read answer, one clock after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rvalid <= 1'b0;
            sel_mem_q  <= 1'b0;
            rval_q     <= '0;
        end else begin
            reg_rvalid <= reg_rd;
            sel_mem_q  <= data_rd_ok;
            rval_q     <= '0;
            if (reg_rd) begin
                case (reg_addr)
                    SEL_CTRL: begin
                        rval_q[CB_CLR_BIT]  <= st_clr;
                        rval_q[CB_WEN_BIT]  <= st_wen;
                        rval_q[CB_LIVE_BIT] <= st_live;
                        rval_q[CB_HIT_BIT]  <= st_hit;
                        rval_q[CB_ARM_BIT]  <= st_arm;
                    end
                    SEL_FILL:  rval_q <= DATA_W'(fill);
                    SEL_LIMIT: rval_q <= DATA_W'(limit);
                    SEL_RPTR:  rval_q <= DATA_W'(rptr);
                    default:   rval_q <= '0;
                endcase
            end
        end
    end

    // Output data: memory words outside the captured region read as zero.
    always_comb begin
        masked    = range_q ? mem_q : '0;
        reg_rdata = !reg_rvalid ? '0 : (sel_mem_q ? masked : rval_q);
        rb_data   = rb_valid ? masked : '0;
    end

    // R6: every read strobe is answered on the next clock.
    a_r6_rvalid_follows_rd: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);
    // R7: a data-port read advances the pointer by one below the top address.
    a_r7_rptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd_ok && !rptr_we && rptr != RPTR_MAX) |=> (rptr == $past(rptr) + 1'b1));
    // R11: a burst never moves the host read pointer.
    a_r11_burst_holds_rptr: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_busy && !rptr_we) |=> $stable(rptr));
    // R8: the burst output is zero whenever no burst word is presented.
    a_r8_idle_rb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rb_valid |-> (rb_data == '0));
endmodule

// File: tb/capbuf_ctrl_tb.sv
// Scoreboard bench: driver tasks push expected read answers and burst words,
// a monitor pops and compares them as the design produces them.
module capbuf_ctrl_tb_top;
    import capbuf_pkg::*;

    localparam int AW    = 6;
    localparam int DW    = 32;
    localparam int LW    = 16;
    localparam int CLONG = 12;
    localparam int CSHRT = 4;
    localparam int DEPTH = 1 << AW;

    typedef struct {
        logic [DW-1:0] d;
        logic          ce;
        logic          dn;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic reg_rvalid;
    logic rb_req = 1'b0;
    logic [AW-1:0] rb_addr = '0;
    logic [LW-1:0] rb_len = '0;
    logic rb_short = 1'b0;
    logic rb_busy, rb_valid, rb_chunk_end, rb_done;
    logic [DW-1:0] rb_data;

    int errors = 0;
    int checks = 0;
    exp_t rq[$];
    exp_t bq[$];

    // Reference model state built from the requirements.
    logic [DW-1:0] m_mem [DEPTH];
    int m_fill = 0, m_limit = DEPTH - 5, m_rptr = 0;
    bit m_clr = 0, m_wen = 0, m_arm = 0, m_hit = 0;

    always #10 clk = ~clk;

    capbuf_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW),
                  .CHUNK_LONG(CLONG), .CHUNK_SHORT(CSHRT)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .rb_req(rb_req), .rb_addr(rb_addr), .rb_len(rb_len), .rb_short(rb_short),
        .rb_busy(rb_busy), .rb_valid(rb_valid), .rb_data(rb_data),
        .rb_chunk_end(rb_chunk_end), .rb_done(rb_done)
    );

    function automatic int lim_eff();
        return (m_limit > DEPTH - 2) ? DEPTH - 2 : m_limit;
    endfunction

    function automatic logic [DW-1:0] exp_word(input int a);
        if (a >= 2 && (a - 2) < m_fill) return m_mem[a];
        return '0;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [DW-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == SEL_CTRL) begin
            m_clr = d[0]; m_wen = d[1];
            if (d[0]) begin m_arm = 1; m_fill = 0; m_hit = 0; end
        end else if (a == SEL_LIMIT) m_limit = int'(d[AW:0]);
        else if (a == SEL_RPTR) m_rptr = int'(d[AW-1:0]);
        @(negedge clk);
    endtask

    task automatic reg_read(input logic [2:0] a, input bit in_burst, input string tag);
        exp_t e;
        bit live;
        live = m_arm && m_wen && !m_clr && !m_hit && (m_fill < lim_eff());
        e.ce = 0; e.dn = 0; e.tag = tag; e.d = '0;
        case (a)
            SEL_CTRL:  e.d = DW'({m_arm, m_hit, live, m_wen, m_clr});
            SEL_FILL:  e.d = DW'(m_fill);
            SEL_LIMIT: e.d = DW'(m_limit);
            SEL_RPTR:  e.d = DW'(m_rptr);
            SEL_DATA:  if (!in_burst) begin
                           e.d = exp_word(m_rptr);
                           if (m_rptr != DEPTH - 1) m_rptr++;
                       end
            default:   e.d = '0;
        endcase
        rq.push_back(e);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic send(input int n, input logic [DW-1:0] base);
        for (int i = 0; i < n; i++) begin
            smp_valid = 1'b1; smp_data = base + DW'(i);
            if (m_arm && m_wen && !m_clr && !m_hit && m_fill < lim_eff()) begin
                m_mem[2 + m_fill] = smp_data;
                m_fill++;
                if (m_fill == lim_eff()) begin m_hit = 1; m_arm = 0; end
            end
            @(negedge clk);
        end
        smp_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic burst(input int start, input int len, input bit sh, input string tag);
        int cs;
        cs = sh ? CSHRT : CLONG;
        for (int i = 0; i < len; i++) begin
            exp_t e;
            int a;
            a = (start + i > DEPTH - 1) ? DEPTH - 1 : start + i;
            e.d = exp_word(a);
            e.ce = ((i % cs) == cs - 1) || (i == len - 1);
            e.dn = (i == len - 1);
            e.tag = tag;
            bq.push_back(e);
        end
        rb_req = 1'b1; rb_addr = AW'(start); rb_len = LW'(len); rb_short = sh;
        @(negedge clk);
        rb_req = 1'b0;
    endtask

    task automatic drain();
        while (rb_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: pop and compare every answer the design presents.
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_rvalid) begin
                if (rq.size() == 0) check("R6 unexpected reg answer", 1, 0);
                else begin
                    exp_t e;
                    e = rq.pop_front();
                    check(e.tag, reg_rdata, e.d);
                end
            end
            if (rb_valid) begin
                if (bq.size() == 0) check("R11 unexpected burst word", 1, 0);
                else begin
                    exp_t e;
                    e = bq.pop_front();
                    check(e.tag, rb_data, e.d);
                    check({e.tag, " chunk_end"}, DW'(rb_chunk_end), DW'(e.ce));
                    check({e.tag, " done"}, DW'(rb_done), DW'(e.dn));
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rb_busy after reset", DW'(rb_busy), 0);
        check("R1 rb_valid after reset", DW'(rb_valid), 0);
        reg_read(SEL_CTRL, 0, "R1 ctrl reset");
        reg_read(SEL_FILL, 0, "R1 fill reset");
        reg_read(SEL_LIMIT, 0, "R1 limit reset");
        reg_read(SEL_RPTR, 0, "R1 rptr reset");
        reg_read(3'd6, 0, "R6 unmapped select");

        // R5: enable without arming stores nothing.
        reg_write(SEL_CTRL, 32'h2);
        send(3, 32'h5500_0000);
        reg_read(SEL_FILL, 0, "R5 fill without arming");

        // R2 then R3: arm, limit 6, capture.
        reg_write(SEL_LIMIT, 32'd6);
        reg_write(SEL_CTRL, 32'h1);
        reg_read(SEL_CTRL, 0, "R2 ctrl while clear held");
        reg_write(SEL_CTRL, 32'h0);
        reg_write(SEL_CTRL, 32'h2);
        reg_read(SEL_CTRL, 0, "R3 ctrl live");
        send(4, 32'hA000_0000);
        reg_read(SEL_FILL, 0, "R3 fill after four");
        reg_read(SEL_CTRL, 0, "R3 still live");

        // R4: limit stops writing.
        send(5, 32'hA000_0010);
        reg_read(SEL_FILL, 0, "R4 fill stops at limit");
        reg_read(SEL_CTRL, 0, "R4 status at limit");
        reg_write(SEL_CTRL, 32'h2);
        send(3, 32'hBB00_0000);
        reg_read(SEL_FILL, 0, "R4 no restart without clear");

        // R7/R8: data port walk across the region edges.
        reg_write(SEL_RPTR, 32'd0);
        for (int i = 0; i < 10; i++) reg_read(SEL_DATA, 0, "R7 R8 data port walk");
        reg_read(SEL_RPTR, 0, "R7 rptr after walk");
        reg_write(SEL_RPTR, DW'(DEPTH - 1));
        reg_read(SEL_DATA, 0, "R8 top address");
        reg_read(SEL_DATA, 0, "R8 top address again");
        reg_read(SEL_RPTR, 0, "R7 rptr saturates");

        // R9/R10: bursts in both chunk modes.
        burst(2, 6, 0, "R9 long mode burst");
        drain();
        burst(0, 10, 1, "R10 short mode burst");
        drain();
        burst(0, 26, 0, "R10 multi chunk burst");
        drain();
        burst(DEPTH - 3, 5, 1, "R9 saturating burst");
        drain();

        // R11: requests and data reads during a burst.
        reg_write(SEL_RPTR, 32'd3);
        burst(1, 8, 0, "R11 burst with interference");
        reg_read(SEL_DATA, 1, "R11 data read while busy");
        rb_req = 1'b1; rb_addr = '0; rb_len = LW'(20); rb_short = 1'b0;
        @(negedge clk);
        rb_req = 1'b0;
        drain();
        reg_read(SEL_RPTR, 0, "R11 rptr unchanged");

        // R12: zero-length request.
        rb_req = 1'b1; rb_addr = 6'd2; rb_len = '0;
        @(negedge clk);
        rb_req = 1'b0;
        check("R12 zero length no busy", DW'(rb_busy), 0);
        @(negedge clk);
        check("R12 zero length no data", DW'(rb_valid), 0);

        // R2: clear empties the buffer.
        reg_write(SEL_CTRL, 32'h1);
        reg_read(SEL_FILL, 0, "R2 fill cleared");
        reg_read(SEL_CTRL, 0, "R2 ctrl after clear");
        reg_write(SEL_RPTR, 32'd2);
        reg_read(SEL_DATA, 0, "R8 old data hidden after clear");

        repeat (4) @(negedge clk);
        check("R9 all burst words delivered", DW'(bq.size()), 0);
        check("R6 all reg answers delivered", DW'(rq.size()), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule